// File: doc/BRIEF.md
# 8-bit Single-Cycle Register Processor

This block is a small 8-bit processor core that finishes one instruction on every rising clock edge. It has no pipeline and no data memory. All of its work happens in a four-entry register file, an ALU and one carry flag. Each cycle the surrounding logic presents a 4-bit opcode, a destination select, a source select and a load byte on pins. The core writes its result at the next edge.

The only result visible outside is a registered output byte. That byte is updated only by the two instructions that export data: one copies a source register to the port, and the other publishes the status byte, which carries the carry flag in bit 0. A tester drives instruction after instruction and watches the port to see the machine state.

The reset input clears the core asynchronously. Release passes through a two-stage synchronizer, so the first two edges after `rst_n` rises still act as reset.

Top module: `byte_core`

## Requirements
- R1: While reset is active, all four registers, the carry flag and `data_out_o` are cleared to zero.
- R2: Opcode 0x0 (move) copies register `src_i` into register `dst_i` at the clock edge.
- R3: Opcode 0x1 (load) writes `load_byte_i` into register `dst_i` at the clock edge.
- R4: Opcode 0x2 (store) drives the value of register `src_i` onto `data_out_o` from the clock edge on.
- R5: Opcode 0x3 (status) writes the status byte {7'b0, carry} both to `data_out_o` and to register `dst_i`.
- R6: The logic operations clear the carry flag. These are 0x4 (dst = ~src), 0x5 (dst = dst & src), 0x6 (dst = dst | src) and 0x9 (dst = dst ^ src).
- R7: Opcode 0x7 sets dst = (dst + src) mod 256, and the carry becomes bit 8 of the unsigned sum.
- R8: Opcode 0x8 sets dst = (dst - src) mod 256. The carry becomes 1 when no borrow occurs (dst >= src) and 0 when a borrow occurs.
- R9: Opcode 0xA sets dst = (src + 1) mod 256, and the carry becomes 1 exactly when src was 0xFF.
- R10: Opcodes 0xB to 0xF change no register, no carry flag and not `data_out_o`.
- R11: `data_out_o` holds its value on every cycle whose opcode is not 0x2 or 0x3.
- R12: Each instruction reads the register values written by the previous instruction, so back-to-back dependent instructions need no stall. This includes the case where one register is both source and destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| op_i | input | 4 | Opcode of the current instruction |
| dst_i | input | 2 | Destination register select; also the first ALU operand |
| src_i | input | 2 | Source register select; also the second ALU operand |
| load_byte_i | input | 8 | Byte written by the load instruction |
| data_out_o | output | 8 | Registered output byte from store or status |

## Verification
The assertions assume that opcode and register selects are known, and stable around each rising edge, whenever the synchronized reset is released. They also assume that only no-operation codes are presented while the reset release ripples through the synchronizer. The bench changes inputs only on the falling edge, holds a no-operation code from time zero until three cycles after reset release, and afterwards issues only fully defined instructions, both directed and pseudo-random.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_MOV = 4'h0;
  localparam logic [OP_W-1:0] OPC_LDB = 4'h1;
  localparam logic [OP_W-1:0] OPC_STB = 4'h2;
  localparam logic [OP_W-1:0] OPC_STS = 4'h3;
  localparam logic [OP_W-1:0] OPC_NOT = 4'h4;
  localparam logic [OP_W-1:0] OPC_AND = 4'h5;
  localparam logic [OP_W-1:0] OPC_OR  = 4'h6;
  localparam logic [OP_W-1:0] OPC_ADD = 4'h7;
  localparam logic [OP_W-1:0] OPC_SUB = 4'h8;
  localparam logic [OP_W-1:0] OPC_XOR = 4'h9;
  localparam logic [OP_W-1:0] OPC_INC = 4'hA;

  typedef enum logic [2:0] {
    FN_PASS, FN_NOT, FN_AND, FN_OR, FN_XOR, FN_ADD, FN_SUB, FN_INC
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_LOAD, WB_STATUS
  } wb_sel_e;

  typedef enum logic {
    OUT_REG, OUT_STATUS
  } out_sel_e;

  typedef struct packed {
    logic     rf_we;
    wb_sel_e  wb_sel;
    logic     out_we;
    out_sel_e out_sel;
    logic     flag_we;
    alu_fn_e  alu_fn;
  } ctrl_t;

endpackage

// File: rtl/bc_rst_sync.sv
module bc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  // Assert asynchronously, release after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/bc_decode.sv
module bc_decode
  import byte_core_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.wb_sel  = WB_ALU;
    ctrl_o.out_sel = OUT_REG;
    ctrl_o.alu_fn  = FN_PASS;
    case (op_i)
      OPC_MOV: begin
        ctrl_o.rf_we = 1'b1;
      end
      OPC_LDB: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_sel = WB_LOAD;
      end
      OPC_STB: begin
        ctrl_o.out_we = 1'b1;
      end
      OPC_STS: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.wb_sel  = WB_STATUS;
        ctrl_o.out_we  = 1'b1;
        ctrl_o.out_sel = OUT_STATUS;
      end
      OPC_NOT: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_NOT;
      end
      OPC_AND: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_AND;
      end
      OPC_OR: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_OR;
      end
      OPC_ADD: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_ADD;
      end
      OPC_SUB: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_SUB;
      end
      OPC_XOR: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_XOR;
      end
      OPC_INC: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.flag_we = 1'b1;
        ctrl_o.alu_fn  = FN_INC;
      end
      default: begin
        // spare codes: no write of any kind
      end
    endcase
  end

endmodule

// File: rtl/bc_alu.sv
module bc_alu
  import byte_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);

  localparam logic [DATA_W:0] ONE_EXT = {{DATA_W{1'b0}}, 1'b1};

  logic [DATA_W:0] ext_sum;

  always_comb begin
    ext_sum = '0;
    res_o   = b_i;
    cout_o  = 1'b0;
    case (fn_i)
      FN_NOT: res_o = ~b_i;
      FN_AND: res_o = a_i & b_i;
      FN_OR:  res_o = a_i | b_i;
      FN_XOR: res_o = a_i ^ b_i;
      FN_ADD: begin
        ext_sum = {1'b0, a_i} + {1'b0, b_i};
        res_o   = ext_sum[DATA_W-1:0];
        cout_o  = ext_sum[DATA_W];
      end
      FN_SUB: begin
        // carry out of a + ~b + 1 is the inverted borrow
        ext_sum = {1'b0, a_i} + {1'b0, ~b_i} + ONE_EXT;
        res_o   = ext_sum[DATA_W-1:0];
        cout_o  = ext_sum[DATA_W];
      end
      FN_INC: begin
        ext_sum = {1'b0, b_i} + ONE_EXT;
        res_o   = ext_sum[DATA_W-1:0];
        cout_o  = ext_sum[DATA_W];
      end
      default: res_o = b_i;
    endcase
  end

endmodule

// File: rtl/bc_regfile.sv
module bc_regfile #(
  parameter  int DATA_W  = 8,
  parameter  int REG_CNT = 4,
  localparam int SEL_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_sel_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] regs_q [REG_CNT];

  for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_entry
    logic entry_en;
    assign entry_en = wr_en && (wr_sel == SEL_W'(gi));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[gi] <= '0;
      end else if (entry_en) begin
        regs_q[gi] <= wr_data;
      end
    end
  end

  assign rd_data_a = regs_q[rd_sel_a];
  assign rd_data_b = regs_q[rd_sel_b];

endmodule

// File: rtl/byte_core.sv
module byte_core
  import byte_core_pkg::*;
#(
  parameter  int DATA_W  = 8,
  parameter  int REG_CNT = 4,
  localparam int SEL_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [SEL_W-1:0]  dst_i,
  input  logic [SEL_W-1:0]  src_i,
  input  logic [DATA_W-1:0] load_byte_i,
  output logic [DATA_W-1:0] data_out_o
);

  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rs_val;
  logic [DATA_W-1:0] alu_res;
  logic              alu_cout;
  logic [DATA_W-1:0] wb_data;
  logic [DATA_W-1:0] status_byte;
  logic              carry_d;
  logic              carry_q;
  logic [DATA_W-1:0] out_d;
  logic [DATA_W-1:0] out_q;

  bc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bc_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  bc_regfile #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT)
  ) u_rf (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .rd_sel_a  (dst_i),
    .rd_sel_b  (src_i),
    .rd_data_a (rd_val),
    .rd_data_b (rs_val),
    .wr_en     (ctrl.rf_we),
    .wr_sel    (dst_i),
    .wr_data   (wb_data)
  );

  bc_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .fn_i   (ctrl.alu_fn),
    .a_i    (rd_val),
    .b_i    (rs_val),
    .res_o  (alu_res),
    .cout_o (alu_cout)
  );

  assign status_byte = {{(DATA_W-1){1'b0}}, carry_q};

  // Next-state logic
  always_comb begin
    case (ctrl.wb_sel)
      WB_LOAD:   wb_data = load_byte_i;
      WB_STATUS: wb_data = status_byte;
      default:   wb_data = alu_res;
    endcase
    carry_d = alu_cout;
    out_d   = (ctrl.out_sel == OUT_STATUS) ? status_byte : rs_val;
  end

  // State registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      carry_q <= 1'b0;
    end else if (ctrl.flag_we) begin
      carry_q <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= '0;
    end else if (ctrl.out_we) begin
      out_q <= out_d;
    end
  end

  assign data_out_o = out_q;

endmodule

// File: rtl/byte_core_chk.sv
module byte_core_chk
  import byte_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] rd_val,
  input logic [DATA_W-1:0] rs_val,
  input logic              carry_q,
  input logic [DATA_W-1:0] data_out
);

  logic [DATA_W:0] add_ext;
  logic            is_logic;
  logic            is_export;
  logic            is_spare;

  assign add_ext   = {1'b0, rd_val} + {1'b0, rs_val};
  assign is_logic  = (op == OPC_NOT) || (op == OPC_AND) || (op == OPC_OR) || (op == OPC_XOR);
  assign is_export = (op == OPC_STB) || (op == OPC_STS);
  assign is_spare  = (op > OPC_INC);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_ni |=> (data_out == '0) && !carry_q);

  p_store_port_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OPC_STB) |=> data_out == $past(rs_val));

  p_status_port_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OPC_STS) |=> (data_out[0] == $past(carry_q)) && (data_out[DATA_W-1:1] == '0));

  p_logic_clears_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    is_logic |=> !carry_q);

  p_add_carry_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OPC_ADD) |=> carry_q == $past(add_ext[DATA_W]));

  p_sub_noborrow_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OPC_SUB) |=> carry_q == $past(rd_val >= rs_val));

  p_inc_wrap_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OPC_INC) |=> carry_q == ($past(rs_val) == {DATA_W{1'b1}}));

  p_spare_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    is_spare |=> $stable(carry_q) && $stable(data_out));

  p_port_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !is_export |=> $stable(data_out));

endmodule

bind byte_core byte_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .op       (op_i),
  .rd_val   (rd_val),
  .rs_val   (rs_val),
  .carry_q  (carry_q),
  .data_out (data_out_o)
);

// File: tb/byte_core_tb.sv
module byte_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_i;
  logic [1:0] dst_i;
  logic [1:0] src_i;
  logic [7:0] load_byte_i;
  logic [7:0] data_out_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_reg [4];
  int m_carry;
  int m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_core u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .dst_i       (dst_i),
    .src_i       (src_i),
    .load_byte_i (load_byte_i),
    .data_out_o  (data_out_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: data_out=%02h expected %02h", tag, act, exp);
    end
  endtask

  // behavioural model of one instruction
  task automatic model_step(input int op, input int d, input int s, input int b);
    int a  = m_reg[d];
    int bb = m_reg[s];
    case (op)
      0:  m_reg[d] = bb;
      1:  m_reg[d] = b;
      2:  m_out = bb;
      3:  begin m_reg[d] = m_carry; m_out = m_carry; end
      4:  begin m_reg[d] = (~bb) & 255; m_carry = 0; end
      5:  begin m_reg[d] = a & bb; m_carry = 0; end
      6:  begin m_reg[d] = a | bb; m_carry = 0; end
      7:  begin m_reg[d] = (a + bb) % 256; m_carry = (a + bb > 255) ? 1 : 0; end
      8:  begin m_reg[d] = (a - bb + 256) % 256; m_carry = (a >= bb) ? 1 : 0; end
      9:  begin m_reg[d] = a ^ bb; m_carry = 0; end
      10: begin m_reg[d] = (bb + 1) % 256; m_carry = (bb == 255) ? 1 : 0; end
      default: ;
    endcase
  endtask

  // drive at the falling edge, let the rising edge commit, compare at the next fall
  task automatic exec(input int op, input int d, input int s, input int b, input string tag);
    op_i        = op[3:0];
    dst_i       = d[1:0];
    src_i       = s[1:0];
    load_byte_i = b[7:0];
    @(posedge clk);
    model_step(op, d, s, b);
    @(negedge clk);
    check(int'(data_out_o), m_out, tag);
  endtask

  task automatic peek(input int r, input int exp, input string tag);
    exec(2, 0, r, 0, tag);
    check(int'(data_out_o), exp, tag);
  endtask

  task automatic read_carry(input int scratch, input int exp, input string tag);
    exec(3, scratch, 0, 0, tag);
    check(int'(data_out_o), exp, tag);
  endtask

  task automatic set_carry();
    exec(1, 0, 0, 8'hFF, "R3");
    exec(1, 1, 0, 8'h01, "R3");
    exec(7, 0, 1, 0, "R7");
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    m_carry     = 0;
    m_out       = 0;
    rst_n       = 1'b0;
    op_i        = 4'hF;
    dst_i       = 2'd0;
    src_i       = 2'd0;
    load_byte_i = 8'h00;
    repeat (4) @(negedge clk);
    check(int'(data_out_o), 0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) exec(15, 0, 0, 0, "R1");

    // R1: reset state of registers and carry
    for (int r = 0; r < 4; r++) peek(r, 0, "R1");
    read_carry(0, 0, "R1");

    // R3 / R4: loads and stores
    exec(1, 0, 0, 8'hF0, "R3");
    exec(1, 1, 0, 8'h20, "R3");
    exec(1, 2, 0, 8'h05, "R3");
    exec(1, 3, 0, 8'h07, "R3");
    peek(0, 8'hF0, "R4");
    peek(3, 8'h07, "R4");

    // R7: add with overflow, then R5 status into register
    exec(7, 0, 1, 0, "R7");
    peek(0, 8'h10, "R7");
    read_carry(3, 8'h01, "R5");
    peek(3, 8'h01, "R5");

    // R2: move
    exec(0, 1, 2, 0, "R2");
    peek(1, 8'h05, "R2");

    // R8: subtract with borrow and without
    exec(1, 3, 0, 8'h07, "R3");
    exec(8, 2, 3, 0, "R8");
    peek(2, 8'hFE, "R8");
    read_carry(2, 8'h00, "R8");
    exec(1, 2, 0, 8'h07, "R3");
    exec(1, 3, 0, 8'h05, "R3");
    exec(8, 2, 3, 0, "R8");
    peek(2, 8'h02, "R8");
    read_carry(1, 8'h01, "R8");
    exec(8, 3, 3, 0, "R8");
    peek(3, 8'h00, "R8");
    read_carry(1, 8'h01, "R8");

    // R9: increment wrap and non-wrap
    exec(1, 0, 0, 8'hFF, "R3");
    exec(10, 1, 0, 0, "R9");
    peek(1, 8'h00, "R9");
    read_carry(3, 8'h01, "R9");
    exec(1, 2, 0, 8'h02, "R3");
    exec(10, 1, 2, 0, "R9");
    peek(1, 8'h03, "R9");
    read_carry(3, 8'h00, "R9");

    // R6: logic operations and carry clearing
    set_carry();
    exec(1, 2, 0, 8'hC3, "R3");
    exec(1, 3, 0, 8'h5A, "R3");
    exec(5, 2, 3, 0, "R6");
    peek(2, 8'h42, "R6");
    read_carry(0, 8'h00, "R6");
    set_carry();
    exec(1, 2, 0, 8'hC3, "R3");
    exec(6, 2, 3, 0, "R6");
    peek(2, 8'hDB, "R6");
    read_carry(0, 8'h00, "R6");
    set_carry();
    exec(1, 2, 0, 8'hC3, "R3");
    exec(9, 2, 3, 0, "R6");
    peek(2, 8'h99, "R6");
    read_carry(0, 8'h00, "R6");
    set_carry();
    exec(4, 2, 3, 0, "R6");
    peek(2, 8'hA5, "R6");
    read_carry(0, 8'h00, "R6");

    // R10: spare opcodes leave registers, carry and port alone
    set_carry();
    peek(3, 8'h5A, "R10");
    for (int op = 11; op < 16; op++) begin
      exec(op, 0, 1, 8'hAA, "R10");
      check(int'(data_out_o), 8'h5A, "R10");
    end
    peek(0, 8'h00, "R10");
    peek(1, 8'h01, "R10");
    read_carry(2, 8'h01, "R10");

    // R12: back-to-back dependent instructions on one register
    exec(1, 0, 0, 8'h03, "R12");
    exec(10, 0, 0, 0, "R12");
    exec(10, 0, 0, 0, "R12");
    exec(7, 0, 0, 0, "R12");
    peek(0, 8'h0A, "R12");

    // R11: pseudo-random stream compared against the model every clock
    for (int i = 0; i < 400; i++) begin
      exec(int'($urandom_range(15, 0)), int'($urandom_range(3, 0)),
           int'($urandom_range(3, 0)), int'($urandom_range(255, 0)), "R11");
    end
    for (int r = 0; r < 4; r++) peek(r, m_reg[r], "R11");

    done = 1'b1;
    finish_run();
  end

endmodule